// File: doc/BRIEF.md
# ATA Task-File Address Remapper

This block sits between the host-facing common-memory / I/O window of a removable ATA storage card and a standard eight-register ATA task file. Each host access carries an offset (the window base is already removed). A two-bit mapping mode folds that offset into a 16-entry register index. The index then decides the path. Some indices are forwarded to the task file. The block answers the others itself: the alternate status port, the device control register and a synthesized drive address byte.

The task-file request is combinational, so the task file sees the access in the same cycle as the host. Read data comes back registered one cycle later, flagged by `host_rvalid`. The block also drives two one-cycle pulses toward the card configuration logic. `srst_req` asks for a card soft reset. `wake_req` asks the configuration logic to leave power-down and raise ready. It also holds the last device-control byte.

Top module: `tf_addr_remap`

## Requirements
- R1: After reset, `dev_ctrl` is 0 and `host_rvalid`, `srst_req` and `wake_req` are all low.
- R2: In mode 0, an offset in 0x400–0x7FF maps to index 0. Any other offset is used unchanged as the index.
- R3: In mode 1, the index is bits 3:0 of the offset.
- R4: In mode 2, an offset in 0x1F0–0x1FF maps to offset−0x1F0 and an offset in 0x3F0–0x3FF maps to offset−0x3E8; for example, 0x3F6 gives index 0xE. Other offsets pass through unchanged.
- R5: In mode 3, an offset in 0x170–0x17F maps to offset−0x170 and an offset in 0x370–0x37F maps to offset−0x368. Other offsets pass through unchanged.
- R6: Indices 0x0 and 0x8 are a 16-bit data transfer at task-file register 0. `tf_req` is high in the same cycle as `host_req`. A read returns all 16 bits on `host_rdata` one cycle later, with `host_rvalid` high.
- R7: Indices 0x1–0x7 access task-file register equal to the index, and indices 0x9–0xC access register index−8. Index 0xD accesses register 1 (error on read, features on write). These reads return the low byte zero-extended. Writes pass all of `host_wdata`.
- R8: A read of index 0xE does not touch the task file. It returns `drive_status` when `drive_present` is high and 0 otherwise. This leaves a pending drive interrupt set, whereas a status read at index 0x7 reaches the task file.
- R9: A write to index 0xE stores `host_wdata[7:0]` in `dev_ctrl` without touching the task file. If bit 2 of the written byte is set, `srst_req` pulses high for one cycle after the write and `dev_ctrl` becomes 0.
- R10: A read of index 0xF returns 0xC2 | ((~select << 2) & 0x3C), which is 0xFE for `drive_select`=0 and 0xFA for 1. Index 0xF never touches the task file.
- R11: A write to an index in 0x1–0x7, 0x9–0xC or 0xF while `pwrdn_in` is high pulses `wake_req` for one cycle after the write. Writes to indices 0x0, 0x8, 0xD, 0xE, and writes of any kind while `pwrdn_in` is low, never raise it.
- R12: A mapped index of 0x10 or above reads 0, makes no task-file access and raises neither `wake_req` nor `srst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Address mapping mode (0 memory, 1 contiguous I/O, 2 primary, 3 secondary) |
| pwrdn_in | input | 1 | Power-down status bit from the configuration registers |
| drive_present | input | 1 | A drive is attached behind the task file |
| drive_select | input | 1 | Currently selected drive bit |
| drive_status | input | 8 | Drive status byte (alternate status source) |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host offset inside the card window |
| host_wdata | input | DATA_W | Host write data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| host_rdata | output | DATA_W | Read data |
| tf_req | output | 1 | Task-file access strobe |
| tf_we | output | 1 | Task-file access is a write |
| tf_idx | output | 3 | Task-file register number |
| tf_wdata | output | DATA_W | Task-file write data |
| tf_rdata | input | DATA_W | Task-file read data (combinational) |
| dev_ctrl | output | 8 | Stored device-control byte |
| srst_req | output | 1 | Card soft-reset request pulse |
| wake_req | output | 1 | Power-down wake request pulse |

## Verification
The bench targets the window edges in modes 2 and 3, for example 0x1EF against 0x1F0 and 0x3F7 against 0x3F8. An off-by-one there would send an access to the wrong register or push a legal port out of range. It reads the alternate status while the stub holds a pending interrupt. A design that forwarded that read would clear the interrupt. It writes the device-control byte with and without the reset bit. A design that kept the byte after a reset request would leave `dev_ctrl` nonzero. It also sends writes to the data, features and control ports while in power-down. A design that woke on every write would pulse `wake_req` for those.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  typedef enum logic [1:0] {
    MAP_MEM  = 2'd0,
    MAP_IO16 = 2'd1,
    MAP_PRI  = 2'd2,
    MAP_SEC  = 2'd3
  } map_mode_e;

  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_DATA  = 3'd1,
    ACC_TASK  = 3'd2,
    ACC_FEAT  = 3'd3,
    ACC_CTRL  = 3'd4,
    ACC_DADDR = 3'd5
  } acc_kind_e;

  localparam int TF_IDX_W   = 3;
  localparam int SRST_BIT   = 2;
  localparam logic [7:0] DADDR_FIXED = 8'hC2;
  localparam logic [7:0] DADDR_MASK  = 8'h3C;

  // drive address byte: fixed pattern plus inverted select folded into bits 5:2
  function automatic logic [7:0] daddr_value(input logic sel);
    logic [7:0] inv;
    inv = ~{7'b0, sel};
    return DADDR_FIXED | ((inv << 2) & DADDR_MASK);
  endfunction

endpackage

// File: rtl/tfr_addr_map.sv
module tfr_addr_map #(
  parameter int ADDR_W      = 11,
  parameter int MEM_WIN_LSB = 10,
  parameter int WIN_LSB     = 4
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] mapped
);
  import tfr_pkg::*;

  localparam int NWIN = 4;
  // windows: primary base, primary alternate, secondary base, secondary alternate
  localparam int WBASE [NWIN] = '{32'h1F0, 32'h3F0, 32'h170, 32'h370};
  localparam int WSUB  [NWIN] = '{32'h1F0, 32'h3E8, 32'h170, 32'h368};

  logic [NWIN-1:0]   hit;
  logic [ADDR_W-1:0] adj [NWIN];

  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE_TAG = ADDR_W'(WBASE[w] >> WIN_LSB);
      assign hit[w] = (offset >> WIN_LSB) == BASE_TAG;
      assign adj[w] = offset - ADDR_W'(WSUB[w]);
    end
  endgenerate

  logic mem_hit;
  assign mem_hit = (offset >> MEM_WIN_LSB) == ADDR_W'(1);

  always_comb begin
    unique case (map_mode_e'(mode))
      MAP_MEM:  mapped = mem_hit ? '0 : offset;
      MAP_IO16: mapped = ADDR_W'(offset[WIN_LSB-1:0]);
      MAP_PRI:  mapped = hit[0] ? adj[0] : (hit[1] ? adj[1] : offset);
      MAP_SEC:  mapped = hit[2] ? adj[2] : (hit[3] ? adj[3] : offset);
      default:  mapped = offset;
    endcase
  end
endmodule

// File: rtl/tfr_idx_decode.sv
module tfr_idx_decode #(
  parameter int ADDR_W  = 11,
  parameter int WIN_LSB = 4
) (
  input  logic [ADDR_W-1:0]              mapped,
  output tfr_pkg::acc_kind_e             kind,
  output logic [tfr_pkg::TF_IDX_W-1:0]   tf_idx
);
  import tfr_pkg::*;

  logic             in_span;
  logic [WIN_LSB-1:0] low;

  assign in_span = (mapped >> WIN_LSB) == '0;
  assign low     = mapped[WIN_LSB-1:0];

  always_comb begin
    kind   = ACC_NONE;
    tf_idx = '0;
    if (in_span) begin
      unique case (low)
        4'h0, 4'h8: begin kind = ACC_DATA;  tf_idx = '0; end
        4'hD:       begin kind = ACC_FEAT;  tf_idx = TF_IDX_W'(1); end
        4'hE:       begin kind = ACC_CTRL;  tf_idx = '0; end
        4'hF:       begin kind = ACC_DADDR; tf_idx = '0; end
        default:    begin kind = ACC_TASK;  tf_idx = low[TF_IDX_W-1:0]; end
      endcase
    end
  end
endmodule

// File: rtl/tf_addr_remap.sv
module tf_addr_remap #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              pwrdn_in,
  input  logic              drive_present,
  input  logic              drive_select,
  input  logic [7:0]        drive_status,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic              tf_req,
  output logic              tf_we,
  output logic [2:0]        tf_idx,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  output logic [7:0]        dev_ctrl,
  output logic              srst_req,
  output logic              wake_req
);
  import tfr_pkg::*;

  localparam int WIN_LSB = 4;
  localparam int PAD_W   = DATA_W - 8;

  logic [ADDR_W-1:0] mapped;
  acc_kind_e         acc_kind;
  logic [TF_IDX_W-1:0] dec_idx;

  tfr_addr_map #(.ADDR_W(ADDR_W), .MEM_WIN_LSB(10), .WIN_LSB(WIN_LSB)) u_map (
    .mode   (mode),
    .offset (host_addr),
    .mapped (mapped)
  );

  tfr_idx_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_dec (
    .mapped (mapped),
    .kind   (acc_kind),
    .tf_idx (dec_idx)
  );

  // named events for the checker
  logic fwd_evt, ctrl_wr_evt, srst_evt, wake_evt, rd_evt;
  assign fwd_evt     = host_req && (acc_kind == ACC_DATA || acc_kind == ACC_TASK ||
                                    acc_kind == ACC_FEAT);
  assign ctrl_wr_evt = host_req && host_we && acc_kind == ACC_CTRL;
  assign srst_evt    = ctrl_wr_evt && host_wdata[SRST_BIT];
  assign wake_evt    = host_req && host_we && pwrdn_in &&
                       (acc_kind == ACC_TASK || acc_kind == ACC_DADDR);
  assign rd_evt      = host_req && !host_we;

  assign tf_req   = fwd_evt;
  assign tf_we    = host_we;
  assign tf_idx   = dec_idx;
  assign tf_wdata = host_wdata;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (acc_kind)
      ACC_DATA:           rd_mux = tf_rdata;
      ACC_TASK, ACC_FEAT: rd_mux = {{PAD_W{1'b0}}, tf_rdata[7:0]};
      ACC_CTRL:           rd_mux = drive_present ? {{PAD_W{1'b0}}, drive_status} : '0;
      ACC_DADDR:          rd_mux = {{PAD_W{1'b0}}, daddr_value(drive_select)};
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      dev_ctrl    <= '0;
      srst_req    <= 1'b0;
      wake_req    <= 1'b0;
    end else begin
      host_rvalid <= rd_evt;
      if (rd_evt) host_rdata <= rd_mux;
      if (srst_evt)         dev_ctrl <= '0;
      else if (ctrl_wr_evt) dev_ctrl <= host_wdata[7:0];
      srst_req <= srst_evt;
      wake_req <= wake_evt;
    end
  end
endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic [DATA_W-1:0]  host_wdata,
  input logic               host_rvalid,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               pwrdn_in,
  input logic               tf_req,
  input logic [7:0]         dev_ctrl,
  input logic               srst_req,
  input logic               wake_req,
  input tfr_pkg::acc_kind_e acc_kind
);
  import tfr_pkg::*;

  AST_ALT_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && acc_kind == ACC_CTRL) |-> !tf_req); // R8

  AST_SRST_ZEROES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |-> dev_ctrl == 8'h00); // R9

  AST_SRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |-> $past(host_req && host_we && host_wdata[SRST_BIT])); // R9

  AST_WAKE_NEEDS_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(pwrdn_in && host_req && host_we)); // R11

  AST_OUT_OF_SPAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && acc_kind == ACC_NONE) |-> !tf_req); // R12

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_req && !host_we)); // R6

  AST_DADDR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(acc_kind == ACC_DADDR)) |-> ((host_rdata[7:0] & 8'hC3) == 8'hC2)); // R10

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({srst_req, wake_req})); // R11
endmodule

bind tf_addr_remap tfr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_wdata  (host_wdata),
  .host_rvalid (host_rvalid),
  .host_rdata  (host_rdata),
  .pwrdn_in    (pwrdn_in),
  .tf_req      (tf_req),
  .dev_ctrl    (dev_ctrl),
  .srst_req    (srst_req),
  .wake_req    (wake_req),
  .acc_kind    (acc_kind)
);

// File: tb/tf_addr_remap_bench.sv
module tf_addr_remap_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;
  localparam int N_RAND = 600;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic              pwrdn_in = 1'b0;
  logic              drive_present = 1'b0;
  logic              drive_select = 1'b0;
  logic [7:0]        drive_status = 8'h00;
  logic              host_req = 1'b0;
  logic              host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic              host_rvalid;
  logic [DATA_W-1:0] host_rdata;
  logic              tf_req, tf_we;
  logic [2:0]        tf_idx;
  logic [DATA_W-1:0] tf_wdata, tf_rdata;
  logic [7:0]        dev_ctrl;
  logic              srst_req, wake_req;

  int checks = 0;
  int errors = 0;
  int exp_ctrl = 0;

  // task-file stub with a pending-interrupt flag cleared by a status read
  logic [DATA_W-1:0] tf_mem [8];
  logic irq_pend = 1'b0;
  logic irq_set = 1'b0;
  assign tf_rdata = tf_mem[tf_idx];
  always @(posedge clk) begin
    if (tf_req && tf_we) tf_mem[tf_idx] <= tf_wdata;
    if (irq_set) irq_pend <= 1'b1;
    else if (tf_req && !tf_we && tf_idx == 3'd7) irq_pend <= 1'b0;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  tf_addr_remap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tf_addr_remap (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pwrdn_in(pwrdn_in),
    .drive_present(drive_present), .drive_select(drive_select),
    .drive_status(drive_status), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .tf_req(tf_req), .tf_we(tf_we), .tf_idx(tf_idx),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .dev_ctrl(dev_ctrl),
    .srst_req(srst_req), .wake_req(wake_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected index, written as explicit ranges
  function automatic int exp_map(input int m, input int off);
    case (m)
      0: return (off >= 'h400 && off <= 'h7FF) ? 0 : off;
      1: return off % 16;
      2: if (off >= 'h1F0 && off <= 'h1FF) return off - 'h1F0;
         else if (off >= 'h3F0 && off <= 'h3FF) return off - 'h3E8;
         else return off;
      default: if (off >= 'h170 && off <= 'h17F) return off - 'h170;
         else if (off >= 'h370 && off <= 'h37F) return off - 'h368;
         else return off;
    endcase
  endfunction

  // kinds: 0 none, 1 data, 2 task, 3 features, 4 control, 5 drive address
  function automatic int exp_kind(input int ix);
    if (ix > 15) return 0;
    if (ix == 0 || ix == 8) return 1;
    if (ix == 13) return 3;
    if (ix == 14) return 4;
    if (ix == 15) return 5;
    return 2;
  endfunction

  function automatic int exp_tfi(input int ix);
    if (ix == 13) return 1;
    if (ix >= 9 && ix <= 12) return ix - 8;
    if (ix >= 1 && ix <= 7) return ix;
    return 0;
  endfunction

  task automatic access(input bit we, input int addr, input int wd, input string req);
    int ix, k, ti, erd;
    bit fwd, ewake, esrst;
    @(negedge clk);
    host_req = 1'b1; host_we = we;
    host_addr = ADDR_W'(addr); host_wdata = DATA_W'(wd);
    ix = exp_map(int'(mode), addr);
    k  = exp_kind(ix);
    ti = exp_tfi(ix);
    fwd = (k == 1 || k == 2 || k == 3);
    #1;
    chk(tf_req == fwd, req, tf_req, fwd);
    if (fwd) chk(int'(tf_idx) == ti && tf_we == we, req, tf_idx, ti);
    case (k)
      1: erd = int'(tf_mem[ti]);
      2, 3: erd = int'(tf_mem[ti]) & 'hFF;
      4: erd = drive_present ? int'(drive_status) : 0;
      5: erd = drive_select ? 'hFA : 'hFE;
      default: erd = 0;
    endcase
    ewake = we && pwrdn_in && (k == 2 || k == 5);
    esrst = we && k == 4 && wd[2];
    if (we && k == 4) exp_ctrl = esrst ? 0 : (wd & 'hFF);
    @(posedge clk); #1;
    chk(host_rvalid == !we, req, host_rvalid, !we);
    if (!we) chk(int'(host_rdata) == erd, req, host_rdata, erd);
    chk(wake_req == ewake, req, wake_req, ewake);
    chk(srst_req == esrst, req, srst_req, esrst);
    chk(int'(dev_ctrl) == exp_ctrl, req, dev_ctrl, exp_ctrl);
    host_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) tf_mem[i] = DATA_W'(16'h1100 * i + 16'h0A5);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dev_ctrl == 0 && !host_rvalid && !srst_req && !wake_req, "R1", dev_ctrl, 0);
    rst_n = 1'b1;

    // R4 primary windows and boundaries
    mode = 2'd2; drive_present = 1'b1; drive_status = 8'h58;
    access(1, 'h1F2, 'h1234, "R4 write 1F2");
    access(0, 'h1F2, 0, "R4 read 1F2");
    access(0, 'h3F6, 0, "R4 R8 alt status");
    access(0, 'h1EF, 0, "R4 R12 below window");
    access(0, 'h3F8, 0, "R4 R12 beyond index F");
    drive_select = 1'b1;
    access(0, 'h3F7, 0, "R4 R10 daddr sel1");
    drive_select = 1'b0;
    access(0, 'h3F7, 0, "R10 daddr sel0");
    access(0, 'h3F0, 0, "R4 R6 data via 8");
    drive_present = 1'b0;
    access(0, 'h3F6, 0, "R8 no drive");

    // R5 secondary windows and pass-through
    mode = 2'd3;
    access(0, 'h376, 0, "R5 alt status");
    access(1, 'h177, 'h00EC, "R5 write 177");
    access(0, 'h005, 0, "R5 unmatched pass");
    access(0, 'h37F, 0, "R5 R12 past F");

    // R2 memory mode, R3 contiguous I/O
    mode = 2'd0;
    access(1, 'h5A3, 'hBEEF, "R2 R6 window data write");
    access(0, 'h000, 0, "R2 R6 data read");
    access(1, 'h00D, 'h0003, "R2 R7 features");
    access(0, 'h00B, 0, "R7 alias B");
    access(0, 'h010, 0, "R12 mem out of span");
    access(1, 'h3FF, 'h5555, "R12 write out of span");
    mode = 2'd1;
    access(0, 'h7E8, 0, "R3 R6 index 8");
    access(0, 'h12D, 0, "R3 R7 error");

    // R9 device control
    access(1, 'h00E, 'h0002, "R9 ctrl store");
    access(1, 'h00E, 'h0006, "R9 ctrl soft reset");
    access(1, 'h00E, 'h00FB, "R9 ctrl no reset bit");

    // R11 wake rules
    pwrdn_in = 1'b1;
    access(1, 'h003, 'h0011, "R11 wake task");
    access(1, 'h00F, 'h0000, "R11 wake daddr");
    access(1, 'h000, 'h0022, "R11 data no wake");
    access(1, 'h00D, 'h0001, "R11 features no wake");
    access(1, 'h00E, 'h0000, "R11 ctrl no wake");
    access(0, 'h003, 0, "R11 read no wake");
    pwrdn_in = 1'b0;
    access(1, 'h004, 'h0033, "R11 awake no pulse");

    // R8 alternate status keeps pending interrupt, status read clears it
    @(negedge clk); irq_set = 1'b1; @(negedge clk); irq_set = 1'b0;
    access(0, 'h00E, 0, "R8 alt read");
    #1 chk(irq_pend == 1'b1, "R8 irq kept", irq_pend, 1);
    access(0, 'h007, 0, "R8 status read");
    #1 chk(irq_pend == 1'b0, "R8 irq cleared", irq_pend, 0);

    // constrained random mix
    for (int n = 0; n < N_RAND; n++) begin
      int bases [9] = '{'h000, 'h1F0, 'h3F0, 'h170, 'h370, 'h400, 'h7F0, 'h010, 'h1E8};
      int a;
      mode = 2'($urandom_range(0, 3));
      pwrdn_in = 1'($urandom_range(0, 1));
      drive_present = 1'($urandom_range(0, 1));
      drive_select = 1'($urandom_range(0, 1));
      drive_status = 8'($urandom);
      if ($urandom_range(0, 3) == 0) a = int'($urandom_range(0, 2047));
      else a = bases[$urandom_range(0, 8)] + int'($urandom_range(0, 15));
      access(1'($urandom_range(0, 1)), a, int'($urandom_range(0, 65535)), "R2 R3 R4 R5 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule